// File: doc/BRIEF.md
# Edge-Selected External Interrupt Controller

This block gathers eight external interrupt lines, five internal peripheral requests and a software trap, and hands a single vector address to an 8-bit CPU core. Each external line responds to one fixed edge polarity and has its own enable bit. A captured edge sets a per-line flag that software reads and clears by writing 1. All eight lines together form one source with one vector. Each internal request is held in its own pending latch until that source is serviced.

The CPU reports each instruction boundary. At a boundary where an eligible request exists, the controller picks the most urgent one, issues a one-cycle acknowledge with the vector address, sets the global interrupt mask and clears that source's latch. The CPU stacks its context, runs the handler and reports the return, and the return clears the mask. Requests that arrive while the mask is set stay latched and wait. The trap is taken whatever the state of the mask. Two wake outputs tell a power controller whether a pending request may end a light or a deep sleep state.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the mask is 1, `irq_ack` is 0, `irq_vector` is 16'hFFFE, `ext_pend` is 0, and no edge is seen from lines that sit at their idle level (low for rising-edge lines, high for falling-edge lines).
- R2: External lines 0, 1, 4 and 5 (RISE_MASK = 8'h33) set their `ext_pend` bit on a 0-to-1 change, and lines 2, 3, 6 and 7 on a 1-to-0 change. The flag is visible the cycle after the edge is sampled. The opposite edge has no effect.
- R3: An edge on a line whose `ext_en` bit is 0 sets no flag, and setting the enable later does not recover that edge.
- R4: Writing 1 to an `ext_clr` bit clears that `ext_pend` bit in the next cycle. An edge sampled in the same cycle as the clear leaves the bit set. A flag never clears without a clear.
- R5: While the mask is 1, no maskable source is acknowledged. Its request stays pending and is acknowledged after the mask clears.
- R6: An acknowledge is issued only in the cycle after a clock edge at which `instr_end` was 1. It lasts one cycle, and `irq_vector` carries the address in that cycle.
- R7: An acknowledge sets the mask. `iret` or `clr_mask` clears it, and `set_mask` sets it. An acknowledge takes precedence over both, and `set_mask` takes precedence over a clear.
- R8: The priority from highest to lowest is trap, flash programming, USB suspend end, external group, timer, SCI, USB. Lower-priority requests stay pending and are served at later boundaries.
- R9: The vectors are: trap FFFCh, flash FFFAh, USB suspend end FFF8h, external group FFF6h, timer FFF4h, SCI FFF0h and USB FFEEh. `periph_req` bit 0 is USB, bit 1 SCI, bit 2 timer, bit 3 USB suspend end and bit 4 flash.
- R10: A trap request is acknowledged even while the mask is 1.
- R11: Serving the external group does not clear `ext_pend`. The group stays requested while any flag is 1.
- R12: `wake_wait` is 1 while any request is latched. `wake_halt` is 1 only while an external flag or the USB suspend end latch is set.
- R13: An internal request that arrives in the same cycle as its own acknowledge stays pending for a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_line | input | 8 | External interrupt lines, already synchronous to clk |
| ext_en | input | 8 | Per-line enable |
| ext_clr | input | 8 | Write-1-to-clear pulses for the per-line flags |
| periph_req | input | 5 | Internal request pulses (USB, SCI, timer, USB suspend end, flash) |
| trap_req | input | 1 | Software trap request pulse |
| instr_end | input | 1 | Instruction boundary from the CPU |
| set_mask | input | 1 | Software sets the global mask |
| clr_mask | input | 1 | Software clears the global mask |
| iret | input | 1 | Return from interrupt, clears the mask |
| ext_pend | output | 8 | Per-line edge flags |
| irq_ack | output | 1 | One-cycle acknowledge to the CPU |
| irq_vector | output | 16 | Vector address of the acknowledged source |
| irq_mask | output | 1 | Current global mask |
| wake_wait | output | 1 | A pending request may end the light sleep state |
| wake_halt | output | 1 | A pending request may end the deep sleep state |

## Verification
The bench builds the block with its default parameters: eight external lines and RISE_MASK = 8'h33. With these values every line can be driven through both of its edge directions and checked against its polarity. Every source can be made pending at the same time, so the bench can follow the whole priority chain, one boundary and one return at a time, down to the last source. The mask-set, trap and same-cycle re-request cases are then tested against that same fixed vector table.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 16;
  localparam int N_SRC  = 7;
  localparam int IDX_W  = $clog2(N_SRC);

  // Index order is also priority order: higher index wins.
  typedef enum logic [IDX_W-1:0] {
    SRC_USB   = 3'd0,
    SRC_SCI   = 3'd1,
    SRC_TIMER = 3'd2,
    SRC_EXT   = 3'd3,
    SRC_SUSP  = 3'd4,
    SRC_FLASH = 3'd5,
    SRC_TRAP  = 3'd6
  } src_e;

  localparam logic [ADDR_W-1:0] VEC_RESET = 16'hFFFE;

  function automatic logic [ADDR_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    case (idx)
      SRC_USB:   vec_of = 16'hFFEE;
      SRC_SCI:   vec_of = 16'hFFF0;
      SRC_TIMER: vec_of = 16'hFFF4;
      SRC_EXT:   vec_of = 16'hFFF6;
      SRC_SUSP:  vec_of = 16'hFFF8;
      SRC_FLASH: vec_of = 16'hFFFA;
      SRC_TRAP:  vec_of = 16'hFFFC;
      default:   vec_of = VEC_RESET;
    endcase
  endfunction
endpackage

// File: rtl/irqc_edge_bank.sv
module irqc_edge_bank #(
  parameter int               N_EXT     = 8,
  parameter logic [N_EXT-1:0] RISE_MASK = 8'h33
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXT-1:0] line,
  input  logic [N_EXT-1:0] en,
  input  logic [N_EXT-1:0] clr,
  output logic [N_EXT-1:0] pend,
  output logic             any
);
  logic [N_EXT-1:0] prev_q;
  logic [N_EXT-1:0] pend_q;
  logic [N_EXT-1:0] edge_hit;

  for (genvar i = 0; i < N_EXT; i++) begin : g_line
    if (RISE_MASK[i]) begin : g_rise
      assign edge_hit[i] = line[i] & ~prev_q[i];
    end else begin : g_fall
      assign edge_hit[i] = ~line[i] & prev_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      // Rising lines start "high", falling lines "low": no edge at release.
      prev_q <= RISE_MASK;
      pend_q <= '0;
    end else begin
      prev_q <= line;
      pend_q <= (pend_q & ~clr) | (edge_hit & en);
    end
  end

  assign pend = pend_q;
  assign any  = |pend_q;
endmodule

// File: rtl/irqc_src_latch.sv
module irqc_src_latch
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_req,
  input  logic [N_SRC-1:0] clr_req,
  output logic [N_SRC-1:0] pend
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i == int'(SRC_EXT)) begin : g_group
      // The external group keeps its state in the edge bank.
      assign pend[i] = 1'b0;
    end else begin : g_latch
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (q & ~clr_req[i]) | set_req[i];
      end
      assign pend[i] = q;
    end
  end
endmodule

// File: rtl/irqc_prio_arb.sv
module irqc_prio_arb #(
  parameter int N     = 7,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IDX_W'(i);
      end
    end
  end

  assign gnt_any = |req;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int               N_EXT     = 8,
  parameter logic [N_EXT-1:0] RISE_MASK = 8'h33
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EXT-1:0]  ext_line,
  input  logic [N_EXT-1:0]  ext_en,
  input  logic [N_EXT-1:0]  ext_clr,
  input  logic [4:0]        periph_req,
  input  logic              trap_req,
  input  logic              instr_end,
  input  logic              set_mask,
  input  logic              clr_mask,
  input  logic              iret,
  output logic [N_EXT-1:0]  ext_pend,
  output logic              irq_ack,
  output logic [ADDR_W-1:0] irq_vector,
  output logic              irq_mask,
  output logic              wake_wait,
  output logic              wake_halt
);
  localparam logic [N_SRC-1:0] NMI_SET = N_SRC'(1) << SRC_TRAP;

  logic             ext_any;
  logic [N_SRC-1:0] int_set;
  logic [N_SRC-1:0] int_pend;
  logic [N_SRC-1:0] src_pend;
  logic [N_SRC-1:0] eligible;
  logic [N_SRC-1:0] gnt;
  logic [IDX_W-1:0] gnt_idx;
  logic             gnt_any;
  logic             take;
  logic             mask_q;
  logic             ack_q;
  logic [ADDR_W-1:0] vec_q;

  irqc_edge_bank #(
    .N_EXT    (N_EXT),
    .RISE_MASK(RISE_MASK)
  ) u_edge (
    .clk (clk),
    .rst (rst),
    .line(ext_line),
    .en  (ext_en),
    .clr (ext_clr),
    .pend(ext_pend),
    .any (ext_any)
  );

  assign int_set = {trap_req, periph_req[4:3], 1'b0, periph_req[2:0]};

  irqc_src_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .set_req(int_set),
    .clr_req(gnt & {N_SRC{take}}),
    .pend   (int_pend)
  );

  always_comb begin
    src_pend          = int_pend;
    src_pend[SRC_EXT] = ext_any;
  end

  assign eligible = mask_q ? (src_pend & NMI_SET) : src_pend;

  irqc_prio_arb #(
    .N    (N_SRC),
    .IDX_W(IDX_W)
  ) u_arb (
    .req    (eligible),
    .gnt    (gnt),
    .gnt_idx(gnt_idx),
    .gnt_any(gnt_any)
  );

  assign take = instr_end & gnt_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 1'b1;
      ack_q  <= 1'b0;
      vec_q  <= VEC_RESET;
    end else begin
      ack_q <= take;
      if (take) vec_q <= vec_of(gnt_idx);
      if (take || set_mask)       mask_q <= 1'b1;
      else if (clr_mask || iret)  mask_q <= 1'b0;
    end
  end

  assign irq_ack    = ack_q;
  assign irq_vector = vec_q;
  assign irq_mask   = mask_q;
  assign wake_wait  = |src_pend;
  assign wake_halt  = ext_any | src_pend[SRC_SUSP];
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_EXT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_EXT-1:0] ext_clr,
  input logic             instr_end,
  input logic [N_EXT-1:0] ext_pend,
  input logic             irq_ack,
  input logic [15:0]      irq_vector,
  input logic             irq_mask,
  input logic             wake_wait,
  input logic             wake_halt
);
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(instr_end)); // R6

  AST_ACK_SETS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> irq_mask); // R7

  AST_MASKED_ONLY_TRAP: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && $past(irq_mask)) |-> (irq_vector == 16'hFFFC)); // R10

  AST_VECTOR_IN_TABLE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (irq_vector inside {16'hFFEE, 16'hFFF0, 16'hFFF4, 16'hFFF6,
                                    16'hFFF8, 16'hFFFA, 16'hFFFC})); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(ext_pend) & ~$past(ext_clr)) & ~ext_pend) == '0)); // R4

  AST_HALT_IMPLIES_WAIT: assert property (@(posedge clk) disable iff (rst)
    wake_halt |-> wake_wait); // R12
endmodule

bind edge_irq_ctrl irqc_checker #(.N_EXT(N_EXT)) u_irqc_checker (
  .clk       (clk),
  .rst       (rst),
  .ext_clr   (ext_clr),
  .instr_end (instr_end),
  .ext_pend  (ext_pend),
  .irq_ack   (irq_ack),
  .irq_vector(irq_vector),
  .irq_mask  (irq_mask),
  .wake_wait (wake_wait),
  .wake_halt (wake_halt)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] RISE = 8'h33;
  localparam logic [7:0] IDLE = ~RISE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0]  ext_line = IDLE;
  logic [7:0]  ext_en = 8'h00;
  logic [7:0]  ext_clr = 8'h00;
  logic [4:0]  periph_req = 5'h00;
  logic trap_req = 1'b0, instr_end = 1'b0, set_mask = 1'b0, clr_mask = 1'b0, iret = 1'b0;
  logic [7:0]  ext_pend;
  logic        irq_ack, irq_mask, wake_wait, wake_halt;
  logic [15:0] irq_vector;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst(rst), .ext_line(ext_line), .ext_en(ext_en), .ext_clr(ext_clr),
    .periph_req(periph_req), .trap_req(trap_req), .instr_end(instr_end),
    .set_mask(set_mask), .clr_mask(clr_mask), .iret(iret), .ext_pend(ext_pend),
    .irq_ack(irq_ack), .irq_vector(irq_vector), .irq_mask(irq_mask),
    .wake_wait(wake_wait), .wake_halt(wake_halt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    periph_req = '0; trap_req = 0; ext_clr = '0;
    set_mask = 0; clr_mask = 0; iret = 0; instr_end = 0;
  endtask

  // Boundary: ack and vector visible right after the edge that samples instr_end.
  task automatic boundary(input string req, input logic exp_ack, input logic [15:0] exp_vec);
    instr_end = 1; step();
    check({req, " ack"}, irq_ack, exp_ack);
    if (exp_ack) begin
      check({req, " vector"}, irq_vector, exp_vec);
      check({req, " mask after entry"}, irq_mask, 1'b1);
    end
  endtask

  task automatic do_iret(); iret = 1; step(); endtask

  task automatic t_reset();
    check("R1 mask", irq_mask, 1'b1);
    check("R1 ack", irq_ack, 1'b0);
    check("R1 vector", irq_vector, 16'hFFFE);
    check("R1 flags", ext_pend, 8'h00);
    step(); step();
    check("R1 no startup edge", ext_pend, 8'h00);
    check("R1 wake", wake_wait, 1'b0);
  endtask

  task automatic t_edges();
    ext_en = 8'hFF;
    for (int i = 0; i < 8; i++) begin
      ext_line[i] = ~IDLE[i]; step();
      check($sformatf("R2 active edge line %0d", i), ext_pend, 8'(1) << i);
      ext_clr = 8'(1) << i; step();
      check($sformatf("R4 clear line %0d", i), ext_pend, 8'h00);
      ext_line[i] = IDLE[i]; step();
      check($sformatf("R2 opposite edge line %0d", i), ext_pend, 8'h00);
    end
  endtask

  task automatic t_disable();
    ext_en = 8'hFD;
    ext_line[1] = 1'b1; step();
    check("R3 disabled line", ext_pend, 8'h00);
    ext_en = 8'hFF; step(); step();
    check("R3 no late capture", ext_pend, 8'h00);
    ext_line[1] = 1'b0; step();
  endtask

  task automatic t_clear_race();
    ext_line[4] = 1'b1; step();
    check("R4 set", ext_pend, 8'h10);
    ext_line[4] = 1'b0; step();
    check("R4 hold without clear", ext_pend, 8'h10);
    ext_line[4] = 1'b1; ext_clr = 8'h10; step();
    check("R4 edge beats clear", ext_pend, 8'h10);
    ext_line[4] = 1'b0; ext_clr = 8'h10; step();
    check("R4 cleared", ext_pend, 8'h00);
  endtask

  task automatic t_mask();
    periph_req = 5'h02; step();
    check("R12 wake_wait", wake_wait, 1'b1);
    check("R12 wake_halt sci", wake_halt, 1'b0);
    boundary("R5 masked sci", 1'b0, 16'h0);
    step();
    boundary("R5 still masked", 1'b0, 16'h0);
    clr_mask = 1; step();
    check("R7 clr_mask", irq_mask, 1'b0);
    boundary("R5 served after unmask", 1'b1, 16'hFFF0);
    check("R12 idle wake", wake_wait, 1'b0);
    do_iret();
    check("R7 iret clears", irq_mask, 1'b0);
    set_mask = 1; iret = 1; step();
    check("R7 set beats clear", irq_mask, 1'b1);
    clr_mask = 1; step();
  endtask

  task automatic t_boundary();
    periph_req = 5'h04; step();
    for (int k = 0; k < 4; k++) begin
      step();
      check("R6 no ack without boundary", irq_ack, 1'b0);
    end
    boundary("R6 timer at boundary", 1'b1, 16'hFFF4);
    step();
    check("R6 one-cycle ack", irq_ack, 1'b0);
    do_iret();
  endtask

  task automatic t_priority();
    periph_req = 5'h1F; trap_req = 1; ext_line[0] = 1'b1; step();
    check("R12 wake_halt", wake_halt, 1'b1);
    boundary("R8 trap first", 1'b1, 16'hFFFC);
    boundary("R8 rest wait under mask", 1'b0, 16'h0);
    do_iret(); boundary("R8 flash", 1'b1, 16'hFFFA);
    do_iret(); boundary("R8 usb suspend", 1'b1, 16'hFFF8);
    do_iret(); boundary("R8 external", 1'b1, 16'hFFF6);
    check("R11 flag kept", ext_pend, 8'h01);
    check("R12 wake_halt by ext", wake_halt, 1'b1);
    do_iret(); boundary("R11 external again", 1'b1, 16'hFFF6);
    ext_clr = 8'h01; step();
    do_iret(); boundary("R8 timer", 1'b1, 16'hFFF4);
    do_iret(); boundary("R8 sci", 1'b1, 16'hFFF0);
    do_iret(); boundary("R8 usb", 1'b1, 16'hFFEE);
    do_iret(); boundary("R8 none left", 1'b0, 16'h0);
    ext_line[0] = 1'b0; step();
  endtask

  task automatic t_trap();
    set_mask = 1; step();
    periph_req = 5'h01; trap_req = 1; step();
    boundary("R10 trap under mask", 1'b1, 16'hFFFC);
    boundary("R10 usb stays masked", 1'b0, 16'h0);
    clr_mask = 1; step();
    boundary("R9 usb vector", 1'b1, 16'hFFEE);
    do_iret();
  endtask

  task automatic t_rereq();
    periph_req = 5'h02; step();
    periph_req = 5'h02; boundary("R13 first sci", 1'b1, 16'hFFF0);
    do_iret(); boundary("R13 sci kept", 1'b1, 16'hFFF0);
    do_iret(); boundary("R13 drained", 1'b0, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_edges();
    t_disable();
    t_clear_race();
    t_mask();
    t_boundary();
    t_priority();
    t_trap();
    t_rereq();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule